// File: doc/BRIEF.md
# Temperature Monitor Configuration Register File

This block holds the software-visible settings of a temperature monitor: a fixed capability word, a configuration word that steers the event output logic, and three threshold registers (alarm upper bound, alarm lower bound, critical limit). It sits behind a plain synchronous bus with an address, write data, a write strobe and combinational read data. The current temperature reading and the event status are inputs that only show up on reads.

Two sticky lock bits in the configuration word protect the settings. Once a lock is set, writes cannot clear it; only the power-on reset can. One lock guards the alarm window and the other guards the critical limit. Both locks also freeze the basic event controls. A write that sets a lock stores its other fields in that same write. Writing the clear-event bit produces a one-cycle pulse for the event logic. That bit is never stored.

Top module: `tmon_regfile`

## Requirements
- R1: Address 00h always reads 0017h, and writes to it have no effect.
- R2: The configuration word at 01h resets to 0000h. On a read, bits 15..11 and bit 5 are 0, and bit 4 shows the `evt_active` input. Bits 0 (mode), 1 (polarity), 2 (critical-only), 3 (output enable), 8 (shutdown), 10..9 (hysteresis), 6 (alarm lock) and 7 (critical lock) read back their stored values.
- R3: Addresses 02h (upper), 03h (lower) and 04h (critical) are 16-bit read/write registers that reset to 0. Address 05h reads `temp_in`, and every other address reads 0000h.
- R4: Once a lock bit is set, a write of 0 does not clear it. Only `rst_n` low clears it.
- R5: While either lock is set, writes leave configuration bits 0, 1 and 3 unchanged.
- R6: While the alarm lock is set, writes leave configuration bit 2 and the registers at 02h and 03h unchanged.
- R7: While the critical lock is set, writes leave 04h unchanged. Each lock leaves the other lock's own registers writable.
- R8: Locks are checked against their value before the write. A write that sets a lock also stores the other configuration bits carried in that write.
- R9: `clear_pulse` is high for exactly the cycle after a configuration write with bit 5 set, whatever the lock state, and is low otherwise.
- R10: The outputs `cfg_mode`, `cfg_pol`, `cfg_crit_only` and `cfg_out_en` equal the stored configuration bits 0, 1, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| bus_addr | input | AW | Register address |
| bus_wdata | input | DW | Write data |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| evt_active | input | 1 | Event asserted status from the event logic |
| temp_in | input | DW | Current temperature reading |
| bus_rdata | output | DW | Read data for `bus_addr` |
| cfg_mode | output | 1 | 0 comparator, 1 interrupt |
| cfg_pol | output | 1 | 0 active low, 1 active high |
| cfg_crit_only | output | 1 | Event only above the critical limit |
| cfg_out_en | output | 1 | Event output enable |
| cfg_shutdown | output | 1 | Sensor shutdown request |
| cfg_hyst | output | 2 | Hysteresis select |
| lock_alarm | output | 1 | Alarm window lock |
| lock_crit | output | 1 | Critical limit lock |
| clear_pulse | output | 1 | One-cycle clear-event request |
| thr_upper | output | DW | Alarm upper bound |
| thr_lower | output | DW | Alarm lower bound |
| thr_crit | output | DW | Critical limit |

## Verification
The assertions assume that `bus_addr`, `bus_wdata` and `bus_wr` are known and stable across each rising edge. They also assume that read data is only meaningful while the address is steady, since the read path is combinational. The stimulus changes every input one time unit after a rising edge and reads the results at the following falling edge. Each write occupies exactly one cycle. `evt_active` and `temp_in` change only between operations, so a read never meets a status input that moves within the same cycle.

// File: rtl/tmon_regfile.sv
module tmon_regfile #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter logic [15:0] CAP_WORD = 16'h0017
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_wr,
  input  logic          evt_active,
  input  logic [DW-1:0] temp_in,
  output logic [DW-1:0] bus_rdata,
  output logic          cfg_mode,
  output logic          cfg_pol,
  output logic          cfg_crit_only,
  output logic          cfg_out_en,
  output logic          cfg_shutdown,
  output logic [1:0]    cfg_hyst,
  output logic          lock_alarm,
  output logic          lock_crit,
  output logic          clear_pulse,
  output logic [DW-1:0] thr_upper,
  output logic [DW-1:0] thr_lower,
  output logic [DW-1:0] thr_crit
);
  localparam logic [AW-1:0] A_CAP  = AW'(0);
  localparam logic [AW-1:0] A_CFG  = AW'(1);
  localparam logic [AW-1:0] A_UPR  = AW'(2);
  localparam logic [AW-1:0] A_LWR  = AW'(3);
  localparam logic [AW-1:0] A_CRT  = AW'(4);
  localparam logic [AW-1:0] A_TMP  = AW'(5);

  logic        wr_cfg, any_lock;
  logic [15:0] cfg_word;
  logic        unused_wbits;

  assign wr_cfg       = bus_wr && (bus_addr == A_CFG);
  assign any_lock     = lock_alarm | lock_crit;
  assign unused_wbits = ^{bus_wdata[15:11], bus_wdata[4]};

  assign cfg_word = {5'b0, cfg_hyst, cfg_shutdown, lock_crit, lock_alarm,
                     1'b0, evt_active, cfg_out_en, cfg_crit_only, cfg_pol, cfg_mode};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_mode      <= 1'b0;
      cfg_pol       <= 1'b0;
      cfg_crit_only <= 1'b0;
      cfg_out_en    <= 1'b0;
      cfg_shutdown  <= 1'b0;
      cfg_hyst      <= 2'b0;
      lock_alarm    <= 1'b0;
      lock_crit     <= 1'b0;
      clear_pulse   <= 1'b0;
      thr_upper     <= '0;
      thr_lower     <= '0;
      thr_crit      <= '0;
    end else begin
      clear_pulse <= wr_cfg && bus_wdata[5];
      if (wr_cfg) begin
        if (!any_lock) begin
          cfg_mode   <= bus_wdata[0];
          cfg_pol    <= bus_wdata[1];
          cfg_out_en <= bus_wdata[3];
        end
        if (!lock_alarm) cfg_crit_only <= bus_wdata[2];
        cfg_shutdown <= bus_wdata[8];
        cfg_hyst     <= bus_wdata[10:9];
        lock_alarm   <= lock_alarm | bus_wdata[6];
        lock_crit    <= lock_crit  | bus_wdata[7];
      end
      if (bus_wr && bus_addr == A_UPR && !lock_alarm) thr_upper <= bus_wdata;
      if (bus_wr && bus_addr == A_LWR && !lock_alarm) thr_lower <= bus_wdata;
      if (bus_wr && bus_addr == A_CRT && !lock_crit)  thr_crit  <= bus_wdata;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CAP:   bus_rdata = DW'(CAP_WORD);
      A_CFG:   bus_rdata = DW'(cfg_word);
      A_UPR:   bus_rdata = thr_upper;
      A_LWR:   bus_rdata = thr_lower;
      A_CRT:   bus_rdata = thr_crit;
      A_TMP:   bus_rdata = temp_in;
      default: bus_rdata = '0;
    endcase
  end
endmodule

module tmon_regfile_chk #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic [DW-1:0] bus_rdata,
  input logic          cfg_mode,
  input logic          cfg_pol,
  input logic          cfg_crit_only,
  input logic          cfg_out_en,
  input logic          lock_alarm,
  input logic          lock_crit,
  input logic          clear_pulse,
  input logic [DW-1:0] thr_upper,
  input logic [DW-1:0] thr_lower,
  input logic [DW-1:0] thr_crit
);
  a_r1_cap_const: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(0)) |-> (bus_rdata == DW'(16'h0017)));
  a_r2_cfg_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(1)) |-> (bus_rdata[15:11] == 5'b0 && !bus_rdata[5]));
  a_r4_alarm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock_alarm |=> lock_alarm);
  a_r4_crit_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock_crit |=> lock_crit);
  a_r5_ctrl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_alarm || lock_crit) |=> ($stable(cfg_mode) && $stable(cfg_pol) && $stable(cfg_out_en)));
  a_r6_window_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    lock_alarm |=> ($stable(thr_upper) && $stable(thr_lower) && $stable(cfg_crit_only)));
  a_r7_crit_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    lock_crit |=> $stable(thr_crit));
  a_r9_pulse_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    clear_pulse |-> $past(bus_wr));
endmodule

bind tmon_regfile tmon_regfile_chk #(.AW(AW), .DW(DW)) chk_i (.*);

// File: tb/tmon_regfile_tb.sv
`timescale 1ns/1ps
module tmon_regfile_tb_top;
  typedef struct {
    int          kind;
    logic [15:0] exp;
    string       req;
  } item_t;

  logic        clk = 0, rst_n = 0, bus_wr = 0, evt_active = 0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0, temp_in = 16'h0123;
  logic [15:0] bus_rdata, thr_upper, thr_lower, thr_crit;
  logic        cfg_mode, cfg_pol, cfg_crit_only, cfg_out_en, cfg_shutdown;
  logic [1:0]  cfg_hyst;
  logic        lock_alarm, lock_crit, clear_pulse;
  int total = 0, bad = 0;
  bit done = 0;
  item_t q[$];

  always #2.5 clk = ~clk;

  tmon_regfile dut_i (.*);

  task automatic push(int kind, logic [15:0] exp, string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic rd(logic [7:0] a, logic [15:0] exp, string req);
    @(posedge clk); #1;
    bus_addr = a;
    push(0, exp, req);
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic wr_pulse(logic [15:0] d, bit exp, string req);
    wr(8'h01, d);
    push(1, {15'b0, exp}, req);
  endtask

  task automatic ports(logic [3:0] exp, string req);
    @(posedge clk); #1;
    push(2, {12'b0, exp}, req);
  endtask

  initial begin : monitor
    logic [15:0] act;
    forever begin
      @(negedge clk);
      if (q.size() != 0) begin
        item_t it;
        it = q.pop_front();
        case (it.kind)
          0: act = bus_rdata;
          1: act = {15'b0, clear_pulse};
          default: act = {12'b0, cfg_out_en, cfg_crit_only, cfg_pol, cfg_mode};
        endcase
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rd(8'h00, 16'h0017, "R1 reset");
    rd(8'h01, 16'h0000, "R2 reset");
    rd(8'h02, 16'h0000, "R3 reset");
    wr(8'h00, 16'hFFFF);
    rd(8'h00, 16'h0017, "R1 write ignored");
    wr_pulse(16'h073F, 1, "R9 pulse");
    rd(8'h01, 16'h070F, "R2 readback");
    evt_active = 1;
    rd(8'h01, 16'h071F, "R2 status bit");
    ports(4'b1111, "R10 ports");
    wr_pulse(16'h0000, 0, "R9 no pulse");
    rd(8'h01, 16'h0010, "R2 clear");
    evt_active = 0;
    ports(4'b0000, "R10 ports cleared");
    wr(8'h02, 16'h1234); wr(8'h03, 16'h0ABC); wr(8'h04, 16'h7FFF);
    rd(8'h02, 16'h1234, "R3 upper");
    rd(8'h03, 16'h0ABC, "R3 lower");
    rd(8'h04, 16'h7FFF, "R3 crit");
    rd(8'h05, 16'h0123, "R3 temp");
    rd(8'h07, 16'h0000, "R3 unmapped");
    wr(8'h01, 16'h0085);
    rd(8'h01, 16'h0085, "R8 same write crit lock");
    ports(4'b0101, "R10 after lock");
    wr(8'h01, 16'h000A);
    rd(8'h01, 16'h0081, "R5 R4 crit lock held");
    wr(8'h04, 16'h0001);
    rd(8'h04, 16'h7FFF, "R7 crit blocked");
    wr(8'h02, 16'h2222);
    rd(8'h02, 16'h2222, "R7 upper free under crit lock");
    wr(8'h01, 16'h0040);
    rd(8'h01, 16'h00C1, "R4 alarm lock set");
    wr(8'h01, 16'h0004);
    rd(8'h01, 16'h00C1, "R6 bit2 blocked");
    wr(8'h02, 16'h5555);
    rd(8'h02, 16'h2222, "R6 upper blocked");
    wr(8'h03, 16'h5555);
    rd(8'h03, 16'h0ABC, "R6 lower blocked");
    wr_pulse(16'h0020, 1, "R9 pulse while locked");
    rd(8'h01, 16'h00C1, "R2 clear bit reads 0");
    @(posedge clk); #1 rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    rd(8'h01, 16'h0000, "R4 reset clears locks");
    rd(8'h04, 16'h0000, "R3 reset crit");
    wr(8'h01, 16'h004B);
    rd(8'h01, 16'h004B, "R8 same write alarm lock");
    wr(8'h04, 16'h0042);
    rd(8'h04, 16'h0042, "R7 crit free under alarm lock");
    wr(8'h03, 16'h0001);
    rd(8'h03, 16'h0000, "R6 lower blocked after reset");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule